// File: doc/BRIEF.md
# Shift-Scaled LMS Coefficient Updater

This block keeps the coefficient bank of an adaptive FIR filter and refreshes every coefficient on each cycle that carries a valid error sample. Each coefficient receives the product of a scaled error and its own input sample: w_i := w_i + (e·2^-K)·x_i. The error arrives from an error-computation stage outside this block and is already delayed. The input samples are delayed to match it before they arrive here. The step size is a power of two, so scaling the error takes an arithmetic right shift and no multiplier.

Each error-by-sample product is formed from 2-bit digits of the sample. Each digit selects 0, 1, 2 or 3 times the scaled error. For the most significant digit the choices are 0, 1, -2 and -1, because the sample is two's complement. The triple of the scaled error is built once and reused by every tap. Each tap then sums its digit products in its own shift-add tree, which holds one pipeline register. The updated coefficients feed back to the filter on `weights_o`.

Error samples use W bits. Input samples use L bits, of which LI are integer bits. Coefficients use W bits and have the same binary point as the scaled error. The full product therefore carries L-LI more fraction bits than a coefficient. Those extra bits are dropped by an arithmetic (floor) shift before the product is added to the coefficient.

Top module: `lms_weight_update`

## Requirements
- R1: While `rst_ni` is low, every coefficient on `weights_o` is zero. Reset is asynchronous.
- R2: If `err_valid_i` is low when an edge samples it, that sample changes no coefficient, whatever `err_i` and `x_i` hold.
- R3: A valid sample updates tap i to sat(w_i + floor((floor(e / 2^K) · x_i) / 2^(L-LI))). Here e is `err_i` as a signed W-bit value and x_i is `x_i[i*L +: L]` as a signed L-bit value.
- R4: Inputs sampled at rising edge t change `weights_o` at edge t+2. The new value is visible after that edge.
- R5: When the sum exceeds the signed W-bit range, the coefficient clamps to 2^(W-1)-1 on the high side or to -2^(W-1) on the low side. It does not wrap.
- R6: The error scaling keeps the sign and rounds toward minus infinity. For example, an error of -1 scales to -1 and not to 0.
- R7: Each tap uses only its own sample. A tap whose sample is zero keeps its value while the other taps update.
- R8: The most negative input sample, -2^(L-1), gives the correct signed product. This exercises the negative weights of the top digit.
- R9: An error that scales to zero leaves all coefficients unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Marks `err_i` and `x_i` as a valid update |
| err_i | input | W | Delayed error, signed |
| x_i | input | N_TAPS*L | Delayed input samples, tap i at bits [i*L +: L], signed |
| weights_o | output | N_TAPS*W | Coefficients, tap i at bits [i*W +: W], signed |

## Verification
The tests use several kinds of directed input. Runs of the largest positive and negative errors against full-scale samples push the coefficients into both clamps, which tells saturation apart from wraparound. Small negative errors and the most negative sample separate a sign-preserving floor shift and a correctly signed top digit from their unsigned variants. Invalid cycles that carry large errors, and cycles where a single tap's sample is zero, show that gating and tap isolation are correct. A long run of seeded random errors, samples and valid flags is compared cycle by cycle against the reference, which also catches any shift in the two-edge latency.

// File: rtl/lms_wu_pkg.sv
package lms_wu_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO  = 2'd0,
    DIG_ONE   = 2'd1,
    DIG_TWO   = 2'd2,
    DIG_THREE = 2'd3
  } digit_e;
endpackage

// File: rtl/lms_wu_ppg.sv
module lms_wu_ppg
  import lms_wu_pkg::*;
#(
  parameter int W = 16,
  parameter int L = 8
) (
  input  logic signed [W-1:0]   mue_i,
  input  logic signed [W+1:0]   mue3_i,
  input  logic        [L-1:0]   x_i,
  output logic [(L/2)*(W+2)-1:0] pp_o
);
  localparam int H  = L / 2;
  localparam int PW = W + 2;

  logic signed [PW-1:0] one_x, two_x, neg_one_x, neg_two_x;
  assign one_x     = PW'(mue_i);
  assign two_x     = one_x <<< 1;
  assign neg_one_x = -one_x;
  assign neg_two_x = -two_x;

  for (genvar j = 0; j < H; j++) begin : g_dig
    digit_e dig;
    assign dig = digit_e'(x_i[2*j +: 2]);
    if (j == H - 1) begin : g_msd
      // top digit is signed: {0, 1, -2, -1}
      always_comb begin
        unique case (dig)
          DIG_ZERO:  pp_o[j*PW +: PW] = '0;
          DIG_ONE:   pp_o[j*PW +: PW] = one_x;
          DIG_TWO:   pp_o[j*PW +: PW] = neg_two_x;
          DIG_THREE: pp_o[j*PW +: PW] = neg_one_x;
          default:   pp_o[j*PW +: PW] = '0;
        endcase
      end
    end else begin : g_lsd
      always_comb begin
        unique case (dig)
          DIG_ZERO:  pp_o[j*PW +: PW] = '0;
          DIG_ONE:   pp_o[j*PW +: PW] = one_x;
          DIG_TWO:   pp_o[j*PW +: PW] = two_x;
          DIG_THREE: pp_o[j*PW +: PW] = mue3_i;
          default:   pp_o[j*PW +: PW] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lms_wu_sadd.sv
module lms_wu_sadd #(
  parameter int W = 16,
  parameter int L = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [(L/2)*(W+2)-1:0]   pp_i,
  output logic signed [W+L-1:0]    prod_o
);
  localparam int H  = L / 2;
  localparam int HL = H / 2;
  localparam int PW = W + 2;
  localparam int P  = W + L;

  logic signed [P-1:0] lo_d, hi_d, lo_q, hi_q, term;

  always_comb begin
    lo_d = '0;
    hi_d = '0;
    term = '0;
    for (int j = 0; j < H; j++) begin
      term = P'($signed(pp_i[j*PW +: PW]));
      term = term <<< (2*j);
      if (j < HL) lo_d = lo_d + term;
      else        hi_d = hi_d + term;
    end
  end

  // single pipeline cut inside the tree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign prod_o = lo_q + hi_q;
endmodule

// File: rtl/lms_weight_update.sv
module lms_weight_update #(
  parameter int N_TAPS   = 4,
  parameter int W        = 16,
  parameter int L        = 8,
  parameter int LI       = 1,
  parameter int MU_SHIFT = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  err_valid_i,
  input  logic [W-1:0]          err_i,
  input  logic [N_TAPS*L-1:0]   x_i,
  output logic [N_TAPS*W-1:0]   weights_o
);
  localparam int P  = W + L;
  localparam int LF = L - LI;
  localparam int H  = L / 2;
  localparam logic signed [P:0] SAT_HI = {{(P-W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [P:0] SAT_LO = {{(P-W+2){1'b1}}, {(W-1){1'b0}}};

  logic signed [W-1:0]  mue_q;
  logic [N_TAPS*L-1:0]  x_q;
  logic                 vld_a, vld_b;
  logic signed [W+1:0]  mue3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mue_q <= '0;
      x_q   <= '0;
      vld_a <= 1'b0;
      vld_b <= 1'b0;
    end else begin
      mue_q <= $signed(err_i) >>> MU_SHIFT;
      x_q   <= x_i;
      vld_a <= err_valid_i;
      vld_b <= vld_a;
    end
  end

  // 3*mue shared by all taps
  assign mue3 = (W+2)'(mue_q) + ((W+2)'(mue_q) <<< 1);

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    logic [H*(W+2)-1:0]  pp;
    logic signed [P-1:0] prod, inc;
    logic signed [P:0]   sum;
    logic signed [W-1:0] w_q, w_d;

    lms_wu_ppg #(.W(W), .L(L)) u_ppg (
      .mue_i  (mue_q),
      .mue3_i (mue3),
      .x_i    (x_q[i*L +: L]),
      .pp_o   (pp)
    );

    lms_wu_sadd #(.W(W), .L(L)) u_sadd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pp_i   (pp),
      .prod_o (prod)
    );

    assign inc = prod >>> LF;
    assign sum = (P+1)'(w_q) + (P+1)'(inc);

    always_comb begin
      if (sum > SAT_HI)      w_d = {1'b0, {(W-1){1'b1}}};
      else if (sum < SAT_LO) w_d = {1'b1, {(W-1){1'b0}}};
      else                   w_d = sum[W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    w_q <= '0;
      else if (vld_b) w_q <= w_d;
    end

    assign weights_o[i*W +: W] = w_q;
  end
endmodule

// File: rtl/lms_wu_chk.sv
module lms_wu_chk #(
  parameter int N_TAPS   = 4,
  parameter int W        = 16,
  parameter int L        = 8,
  parameter int LI       = 1,
  parameter int MU_SHIFT = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                err_valid_i,
  input logic [W-1:0]        err_i,
  input logic [N_TAPS*L-1:0] x_i,
  input logic [N_TAPS*W-1:0] weights_o
);
  logic c1, c2, ez1, ez2;
  logic [N_TAPS*L-1:0] x1, x2;
  logic signed [W-1:0] err_scaled;

  assign err_scaled = $signed(err_i) >>> MU_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1 <= 1'b0; c2 <= 1'b0; ez1 <= 1'b0; ez2 <= 1'b0;
      x1 <= '0;   x2 <= '0;
    end else begin
      c1 <= err_valid_i; c2 <= c1;
      ez1 <= (err_scaled == '0); ez2 <= ez1;
      x1 <= x_i; x2 <= x1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_zero_R1: assert (weights_o == '0);
  end

  assert_hold_invalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c2 |=> $stable(weights_o));

  assert_zero_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2 && ez2) |=> $stable(weights_o));

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assert_tap_isolated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c2 && x2[i*L +: L] == '0) |=> $stable(weights_o[i*W +: W]));
  end
endmodule

bind lms_weight_update lms_wu_chk #(
  .N_TAPS(N_TAPS), .W(W), .L(L), .LI(LI), .MU_SHIFT(MU_SHIFT)
) u_chk (.*);

// File: tb/tb_lms_weight_update.sv
module tb_lms_weight_update;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int L  = 8;
  localparam int LI = 1;
  localparam int K  = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              err_valid_i = 1'b0;
  logic [W-1:0]      err_i = '0;
  logic [N*L-1:0]    x_i = '0;
  logic [N*W-1:0]    weights_o;

  int checks = 0;
  int fails  = 0;
  longint exp_w [N];
  bit     p1v, p2v;
  logic [W-1:0]   p1e, p2e;
  logic [N*L-1:0] p1x, p2x;

  lms_weight_update #(.N_TAPS(N), .W(W), .L(L), .LI(LI), .MU_SHIFT(K)) dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic longint ref_upd(longint w, logic [W-1:0] e, logic [L-1:0] x);
    longint mue, prod, inc, s;
    mue  = longint'($signed(e)) >>> K;   // floor shift, R6
    prod = mue * longint'($signed(x));
    inc  = prod >>> (L - LI);
    s    = w + inc;
    if (s > (longint'(1) << (W-1)) - 1) s = (longint'(1) << (W-1)) - 1;  // R5
    if (s < -(longint'(1) << (W-1)))    s = -(longint'(1) << (W-1));
    return s;
  endfunction

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) begin
      longint act;
      act = longint'($signed(weights_o[i*W +: W]));
      checks++;
      if (act != exp_w[i]) begin
        fails++;
        $display("FAIL %s tap %0d: actual %0d expected %0d", tag, i, act, exp_w[i]);
      end
    end
  endtask

  task automatic step(bit v, logic [W-1:0] e, logic [N*L-1:0] x, string tag);
    err_valid_i = v; err_i = e; x_i = x;
    @(posedge clk_i);
    if (p2v) for (int i = 0; i < N; i++) exp_w[i] = ref_upd(exp_w[i], p2e, p2x[i*L +: L]);
    p2v = p1v; p2e = p1e; p2x = p1x;
    p1v = v;   p1e = e;   p1x = x;
    @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    err_valid_i = 1'b0;
    #1;
    for (int i = 0; i < N; i++) exp_w[i] = 0;
    p1v = 0; p2v = 0;
    check_all("R1");
    @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
  endtask

  function automatic logic [N*L-1:0] rep_x(logic [L-1:0] v);
    logic [N*L-1:0] r;
    for (int i = 0; i < N; i++) r[i*L +: L] = v;
    return r;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    #1 rst_ni = 1'b0;
    for (int i = 0; i < N; i++) exp_w[i] = 0;
    p1v = 0; p2v = 0;
    do_reset();

    // R4: one valid vector, weights must not move for two edges
    step(1'b1, 16'sd8000, rep_x(8'sd64), "R4");
    step(1'b0, 16'sd0, '0, "R4");
    step(1'b0, 16'sd0, '0, "R4");
    step(1'b0, 16'sd0, '0, "R4");

    // R2: invalid cycles with large data
    for (int c = 0; c < 6; c++) step(1'b0, 16'h7fff, rep_x(8'h7f), "R2");

    // R9: error below one shift step
    for (int c = 0; c < 4; c++) step(1'b1, 16'sd7, rep_x(8'h7f), "R9");

    // R6: negative small error floors to -1
    for (int c = 0; c < 4; c++) step(1'b1, -16'sd1, rep_x(8'sd100), "R6");

    // R7: one tap with zero sample
    for (int c = 0; c < 4; c++) step(1'b1, 16'sd12000, {8'sd90, 8'sd0, -8'sd40, 8'sd17}, "R7");

    // R8: most negative sample
    for (int c = 0; c < 4; c++) step(1'b1, 16'sd9000, rep_x(8'h80), "R8");

    // R5: drive to positive then negative clamp
    for (int c = 0; c < 16; c++) step(1'b1, 16'h7fff, rep_x(8'h7f), "R5");
    for (int c = 0; c < 30; c++) step(1'b1, 16'h8000, rep_x(8'h7f), "R5");
    for (int c = 0; c < 4; c++)  step(1'b1, 16'h8000, rep_x(8'h80), "R5");
    for (int c = 0; c < 4; c++)  step(1'b0, 16'h0, '0, "R5");

    // R3: random traffic
    for (int c = 0; c < 3000; c++)
      step(($urandom % 4) != 0, W'($urandom), {$urandom}, "R3");
    for (int c = 0; c < 3; c++) step(1'b0, '0, '0, "R3");

    do_reset();
    finish_run();
  end
endmodule